// File: doc/BRIEF.md
# Cascadable FIFO Slice Chain

A first-in first-out buffer assembled from identical slices connected in a ring. Every slice sees the same write strobe, read strobe, write data and read strobe, but a slice acts on a write only while it owns the write token, and it drives read data only while it owns the read token. A slice that stores into its last physical word hands the write token to its neighbour with a one-cycle pulse. A slice that consumes its last physical word hands on the read token the same way. The buffer therefore holds SLICES times DEPTH words without a shared address counter.

Write and read pass pulses travel on separate wires, so both tokens can move on the same clock edge. The wrapper names slice 0 as the first slice by tying its first-load input active. It closes the ring and forms the composite flags: empty is the empty flag of the read-token owner, and full is the full flag of the write-token owner. Read data is shown ahead: the oldest word sits on `rd_data` with `rd_valid` high, and a read strobe consumes it on the next clock edge.

Top module: `cfifo_chain`

## Requirements
- R1: While `rst_n` is low and after its release, `empty`=1, `full`=0 and `rd_valid`=0. All bits of `slice_empty` are 1 and all bits of `slice_full` are 0. `wr_own` and `rd_own` both equal 1 (bit 0 = slice 0 holds both tokens).
- R2: Words leave in exactly the order they were accepted, across slice boundaries and around the ring.
- R3: `full` is 1 exactly when SLICES*DEPTH words are held. A write strobe while `full` is 1 stores nothing and moves no token, even when a read occurs in the same cycle.
- R4: A read strobe while `empty` is 1 has no effect: `rd_own` is unchanged and a later write is the next word read.
- R5: The write token moves from slice k to slice (k+1) mod SLICES on the clock edge that stores into slice k's last location. `wr_own` bit k marks slice k.
- R6: The read token moves from slice k to slice (k+1) mod SLICES on the clock edge that consumes slice k's last location. `rd_own` bit k marks slice k.
- R7: Exactly one bit of `wr_own` and exactly one bit of `rd_own` are set at all times.
- R8: A read and a write in the same cycle both take effect, including when both tokens pass on that edge.
- R9: `slice_full` bit k is 1 when slice k holds DEPTH words. `slice_empty` bit k is 1 when slice k holds none.
- R10: `rd_valid` equals not `empty`. While `rd_valid` is 1, `rd_data` is the oldest word held.
- R11: `empty` equals the empty flag of the read-token owner, and `full` equals the full flag of the write-token owner.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe shared by all slices |
| wr_data | input | WIDTH | Write data shared by all slices |
| rd_en | input | 1 | Read strobe shared by all slices |
| rd_data | output | WIDTH | Oldest word, zero when nothing is held |
| rd_valid | output | 1 | Data-out-valid from the read-token owner |
| full | output | 1 | Composite full flag |
| empty | output | 1 | Composite empty flag |
| slice_empty | output | SLICES | Per-slice empty flags |
| slice_full | output | SLICES | Per-slice full flags |
| wr_own | output | SLICES | Write-token ownership, one bit per slice |
| rd_own | output | SLICES | Read-token ownership, one bit per slice |

## Verification
The bench first fills the whole chain and then drains it. This shows whether each token hands over at the exact last-word edge and whether the writer comes back around to slice 0. Strobes beyond capacity and below zero, including a write at full paired with a read, separate correct flag qualification from leaks that corrupt pointers. A case that lines up the writer and the reader on their last locations in the same cycle exposes lost or merged pass pulses. Long pseudo-random mixes with write-heavy and read-heavy bias keep the occupancy moving across every slice boundary. Throughout, data order and every per-slice flag are compared with a reference queue.

// File: rtl/cfifo_pkg.sv
package cfifo_pkg;

   // index width for a slice of the given depth, never below one bit
   function automatic int ptr_w(input int depth);
      return (depth <= 2) ? 1 : $clog2(depth);
   endfunction

   // count width able to hold 0..depth
   function automatic int cnt_w(input int depth);
      return $clog2(depth + 1);
   endfunction

   function automatic bit is_pow2(input int v);
      return (v > 0) && ((v & (v - 1)) == 0);
   endfunction

endpackage

// File: rtl/cfifo_ring_ptr.sv
// Location pointer plus ownership token for one direction of one slice.
module cfifo_ring_ptr #(
   parameter int DEPTH = 8,
   localparam int AW   = cfifo_pkg::ptr_w(DEPTH)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          first_load,
   input  logic          adv,
   input  logic          pass_in,
   output logic          own,
   output logic [AW-1:0] ptr,
   output logic          pass_out
);

   localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

   logic at_last;

   assign at_last  = (ptr == LAST);
   assign pass_out = adv & at_last;

   // an arriving pass wins over a leaving one (single-slice ring)
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         own <= first_load;
      else if (pass_in)
         own <= 1'b1;
      else if (pass_out)
         own <= 1'b0;
   end

   generate
      if (cfifo_pkg::is_pow2(DEPTH)) begin : g_wrap_natural
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               ptr <= '0;
            else if (adv)
               ptr <= ptr + 1'b1;
         end
      end else begin : g_wrap_compare
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               ptr <= '0;
            else if (adv)
               ptr <= at_last ? '0 : ptr + 1'b1;
         end
      end
   endgenerate

endmodule

// File: rtl/cfifo_store.sv
// Word storage of one slice: synchronous write, combinational read.
module cfifo_store #(
   parameter int WIDTH = 9,
   parameter int DEPTH = 8,
   localparam int AW   = cfifo_pkg::ptr_w(DEPTH)
) (
   input  logic             clk,
   input  logic             we,
   input  logic [AW-1:0]    waddr,
   input  logic [WIDTH-1:0] wdata,
   input  logic [AW-1:0]    raddr,
   output logic [WIDTH-1:0] rdata
);

   logic [WIDTH-1:0] mem [DEPTH];

   always_ff @(posedge clk) begin
      if (we)
         mem[waddr] <= wdata;
   end

   assign rdata = mem[raddr];

endmodule

// File: rtl/cfifo_slice.sv
// One chainable slice: storage, two token pointers, occupancy and flags.
module cfifo_slice #(
   parameter int WIDTH = 9,
   parameter int DEPTH = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             first_load,
   input  logic             wr_en,
   input  logic [WIDTH-1:0] wr_data,
   input  logic             rd_en,
   input  logic             wtok_in,
   input  logic             rtok_in,
   output logic             wtok_out,
   output logic             rtok_out,
   output logic [WIDTH-1:0] rd_data,
   output logic             rd_valid,
   output logic             empty,
   output logic             full,
   output logic             wr_own,
   output logic             rd_own
);

   localparam int AW = cfifo_pkg::ptr_w(DEPTH);
   localparam int CW = cfifo_pkg::cnt_w(DEPTH);
   localparam logic [CW-1:0] FULL_CNT = CW'(DEPTH);

   logic [AW-1:0]    wptr, rptr;
   logic [CW-1:0]    cnt;
   logic             wacc, racc;
   logic [WIDTH-1:0] mem_q;

   assign wacc = wr_en & wr_own & ~full;
   assign racc = rd_en & rd_own & ~empty;

   cfifo_ring_ptr #(.DEPTH(DEPTH)) u_wptr (
      .clk(clk), .rst_n(rst_n), .first_load(first_load),
      .adv(wacc), .pass_in(wtok_in),
      .own(wr_own), .ptr(wptr), .pass_out(wtok_out)
   );

   cfifo_ring_ptr #(.DEPTH(DEPTH)) u_rptr (
      .clk(clk), .rst_n(rst_n), .first_load(first_load),
      .adv(racc), .pass_in(rtok_in),
      .own(rd_own), .ptr(rptr), .pass_out(rtok_out)
   );

   cfifo_store #(.WIDTH(WIDTH), .DEPTH(DEPTH)) u_mem (
      .clk(clk), .we(wacc), .waddr(wptr), .wdata(wr_data),
      .raddr(rptr), .rdata(mem_q)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         cnt <= '0;
      else begin
         case ({wacc, racc})
            2'b10:   cnt <= cnt + 1'b1;
            2'b01:   cnt <= cnt - 1'b1;
            default: cnt <= cnt;
         endcase
      end
   end

   assign empty    = (cnt == '0);
   assign full     = (cnt == FULL_CNT);
   assign rd_valid = rd_own & ~empty;
   assign rd_data  = rd_valid ? mem_q : '0;

endmodule

// File: rtl/cfifo_chain.sv
// Ring of SLICES identical slices with composite flags.
module cfifo_chain #(
   parameter int WIDTH  = 9,
   parameter int DEPTH  = 8,
   parameter int SLICES = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [WIDTH-1:0]  wr_data,
   input  logic              rd_en,
   output logic [WIDTH-1:0]  rd_data,
   output logic              rd_valid,
   output logic              full,
   output logic              empty,
   output logic [SLICES-1:0] slice_empty,
   output logic [SLICES-1:0] slice_full,
   output logic [SLICES-1:0] wr_own,
   output logic [SLICES-1:0] rd_own
);

   generate
      if (WIDTH < 1) begin : g_bad_width
         $error("cfifo_chain: WIDTH must be at least 1");
      end
      if (DEPTH < 2) begin : g_bad_depth
         $error("cfifo_chain: DEPTH must be at least 2");
      end
      if (SLICES < 1) begin : g_bad_slices
         $error("cfifo_chain: SLICES must be at least 1");
      end
   endgenerate

   logic [SLICES-1:0]             wpass, rpass;
   logic [SLICES-1:0]             s_valid;
   logic [SLICES-1:0][WIDTH-1:0]  s_data;

   genvar i;
   generate
      for (i = 0; i < SLICES; i++) begin : g_slice
         localparam int PREV = (i + SLICES - 1) % SLICES;
         cfifo_slice #(.WIDTH(WIDTH), .DEPTH(DEPTH)) u_slice (
            .clk        (clk),
            .rst_n      (rst_n),
            .first_load (i == 0),
            .wr_en      (wr_en),
            .wr_data    (wr_data),
            .rd_en      (rd_en),
            .wtok_in    (wpass[PREV]),
            .rtok_in    (rpass[PREV]),
            .wtok_out   (wpass[i]),
            .rtok_out   (rpass[i]),
            .rd_data    (s_data[i]),
            .rd_valid   (s_valid[i]),
            .empty      (slice_empty[i]),
            .full       (slice_full[i]),
            .wr_own     (wr_own[i]),
            .rd_own     (rd_own[i])
         );
      end
   endgenerate

   // non-owners drive zero, so an OR merges the read side
   always_comb begin
      rd_data = '0;
      for (int k = 0; k < SLICES; k++)
         rd_data = rd_data | s_data[k];
   end

   assign rd_valid = |s_valid;
   assign empty    = |(slice_empty & rd_own);
   assign full     = |(slice_full & wr_own);

endmodule

// File: rtl/cfifo_chain_chk.sv
module cfifo_chain_chk #(
   parameter int SLICES = 4
) (
   input logic              clk,
   input logic              rst_n,
   input logic              wr_en,
   input logic              rd_en,
   input logic              rd_valid,
   input logic              full,
   input logic              empty,
   input logic [SLICES-1:0] wr_own,
   input logic [SLICES-1:0] rd_own
);

   assert_one_wr_owner_R7: assert property (@(posedge clk) disable iff (!rst_n)
      $countones(wr_own) == 1);

   assert_one_rd_owner_R7: assert property (@(posedge clk) disable iff (!rst_n)
      $countones(rd_own) == 1);

   assert_full_holds_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (full && wr_en && !rd_en) |=> (full && $stable(wr_own)));

   assert_empty_holds_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (empty && rd_en && !wr_en) |=> (empty && $stable(rd_own)));

   assert_wtok_moves_on_write_R5: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(wr_own) |-> $past(wr_en));

   assert_rtok_moves_on_read_R6: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(rd_own) |-> $past(rd_en));

   assert_valid_tracks_empty_R10: assert property (@(posedge clk) disable iff (!rst_n)
      rd_valid == !empty);

endmodule

bind cfifo_chain cfifo_chain_chk #(.SLICES(SLICES)) u_chk (
   .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en),
   .rd_valid(rd_valid), .full(full), .empty(empty),
   .wr_own(wr_own), .rd_own(rd_own)
);

// File: tb/sim_cfifo_chain.sv
`timescale 1ns/1ps
module sim_cfifo_chain;

   localparam int W   = 9;
   localparam int D   = 8;
   localparam int S   = 4;
   localparam int CAP = D * S;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          wr_en = 1'b0;
   logic [W-1:0]  wr_data = '0;
   logic          rd_en = 1'b0;
   logic [W-1:0]  rd_data;
   logic          rd_valid, full, empty;
   logic [S-1:0]  slice_empty, slice_full, wr_own, rd_own;

   int vectors = 0;
   int misses  = 0;

   int q[$];
   int scnt[S];
   int wtot = 0;
   int rtot = 0;
   logic [15:0] lfsr = 16'hACE1;

   always #4 clk = ~clk;   // 125 MHz

   cfifo_chain #(.WIDTH(W), .DEPTH(D), .SLICES(S)) u0 (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
      .rd_en(rd_en), .rd_data(rd_data), .rd_valid(rd_valid),
      .full(full), .empty(empty), .slice_empty(slice_empty),
      .slice_full(slice_full), .wr_own(wr_own), .rd_own(rd_own)
   );

   task automatic chk(input bit ok, input string tag, input string what,
                      input int act, input int exp);
      vectors++;
      if (!ok) begin
         misses++;
         $display("FAIL %s %s: actual %0h expected %0h at %0t", tag, what, act, exp, $time);
      end
   endtask

   task automatic check_state(input string tag);
      logic [S-1:0] ew, er, ee, ef;
      ew = S'(1) << ((wtot / D) % S);
      er = S'(1) << ((rtot / D) % S);
      for (int k = 0; k < S; k++) begin
         ee[k] = (scnt[k] == 0);
         ef[k] = (scnt[k] == D);
      end
      chk(empty == (q.size() == 0), tag, "empty R11", int'(empty), int'(q.size() == 0));
      chk(full == (q.size() == CAP), tag, "full R3", int'(full), int'(q.size() == CAP));
      chk(rd_valid == (q.size() != 0), tag, "rd_valid R10", int'(rd_valid), int'(q.size() != 0));
      if (q.size() != 0)
         chk(int'(rd_data) == q[0], tag, "rd_data R2", int'(rd_data), q[0]);
      chk(wr_own == ew, tag, "wr_own R5", int'(wr_own), int'(ew));
      chk(rd_own == er, tag, "rd_own R6", int'(rd_own), int'(er));
      chk(slice_empty == ee, tag, "slice_empty R9", int'(slice_empty), int'(ee));
      chk(slice_full == ef, tag, "slice_full R9", int'(slice_full), int'(ef));
   endtask

   // one clock: drive strobes, update reference on the edge, then compare
   task automatic cyc(input bit we, input int wd, input bit re, input string tag);
      bit wacc, racc;
      int wo, ro;
      wr_en   = we;
      wr_data = W'(wd);
      rd_en   = re;
      wacc = we && (q.size() < CAP);
      racc = re && (q.size() > 0);
      wo = (wtot / D) % S;
      ro = (rtot / D) % S;
      @(posedge clk);
      if (racc) begin
         void'(q.pop_front());
         scnt[ro]--;
         rtot++;
      end
      if (wacc) begin
         q.push_back(wd & ((1 << W) - 1));
         scnt[wo]++;
         wtot++;
      end
      #1;
      wr_en = 1'b0;
      rd_en = 1'b0;
      check_state(tag);
   endtask

   task automatic do_reset();
      wr_en = 1'b0;
      rd_en = 1'b0;
      rst_n = 1'b0;
      q.delete();
      for (int k = 0; k < S; k++) scnt[k] = 0;
      wtot = 0;
      rtot = 0;
      repeat (3) @(posedge clk);
      #1;
      check_state("R1 in reset");
      rst_n = 1'b1;
      @(posedge clk);
      #1;
      check_state("R1 after release");
   endtask

   function automatic int nxt();
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      return int'(lfsr);
   endfunction

   // fill the whole ring, then drain it, crossing every slice boundary
   task automatic t_fill_drain();
      do_reset();
      for (int n = 0; n < CAP; n++) cyc(1'b1, 'h40 + n, 1'b0, "R5 fill");
      chk(full == 1'b1, "R3", "full after capacity", int'(full), 1);
      for (int n = 0; n < CAP; n++) cyc(1'b0, 0, 1'b1, "R6 drain");
      chk(wr_own == S'(1), "R5", "writer wrapped to slice 0", int'(wr_own), 1);
      chk(rd_own == S'(1), "R6", "reader wrapped to slice 0", int'(rd_own), 1);
      for (int n = 0; n < D + 3; n++) cyc(1'b1, 'h100 + n, 1'b0, "R2 second lap");
      for (int n = 0; n < D + 3; n++) cyc(1'b0, 0, 1'b1, "R2 second lap drain");
   endtask

   // writes beyond capacity, alone and paired with reads
   task automatic t_overflow();
      do_reset();
      for (int n = 0; n < CAP; n++) cyc(1'b1, n * 3, 1'b0, "R3 fill");
      for (int n = 0; n < 4; n++) cyc(1'b1, 'h1AA, 1'b0, "R3 write at full");
      cyc(1'b1, 'h155, 1'b1, "R3 write at full with read");
      cyc(1'b1, 'h0F0, 1'b1, "R8 rw after full");
      for (int n = 0; n < CAP; n++) cyc(1'b0, 0, 1'b1, "R3 drain");
   endtask

   // reads on an empty ring must not move anything
   task automatic t_underflow();
      do_reset();
      for (int n = 0; n < 5; n++) cyc(1'b0, 0, 1'b1, "R4 read at empty");
      cyc(1'b1, 'h0C3, 1'b0, "R4 write after empty reads");
      chk(int'(rd_data) == 'h0C3, "R4", "first word after empty reads", int'(rd_data), 'h0C3);
      cyc(1'b0, 0, 1'b1, "R4 read back");
      for (int n = 0; n < 3; n++) cyc(1'b0, 0, 1'b1, "R4 read at empty again");
   endtask

   // both tokens leave their slices on the same edge
   task automatic t_both_pass();
      do_reset();
      for (int n = 0; n < 2 * D - 1; n++) cyc(1'b1, 'h80 + n, 1'b0, "R8 setup fill");
      for (int n = 0; n < D - 1; n++) cyc(1'b0, 0, 1'b1, "R8 setup read");
      cyc(1'b1, 'h1F1, 1'b1, "R8 both tokens pass");
      chk(wr_own == S'(4), "R8", "writer at slice 2", int'(wr_own), 4);
      chk(rd_own == S'(2), "R8", "reader at slice 1", int'(rd_own), 2);
      for (int n = 0; n < D + 1; n++) cyc(1'b0, 0, 1'b1, "R8 drain");
   endtask

   // pseudo-random mixes with changing bias
   task automatic t_mix(input int cycles, input int wbias, input string tag);
      for (int n = 0; n < cycles; n++) begin
         int r;
         r = nxt();
         cyc((r & 3) < wbias, nxt(), ((r >> 2) & 3) >= wbias, tag);
      end
   endtask

   task automatic t_random();
      do_reset();
      t_mix(200, 3, "R2 write-heavy mix");
      t_mix(200, 1, "R2 read-heavy mix");
      t_mix(400, 2, "R8 balanced mix");
      do_reset();
      t_mix(150, 2, "R8 balanced after reset");
   endtask

   initial begin
      for (int k = 0; k < S; k++) scnt[k] = 0;
      t_fill_drain();
      t_overflow();
      t_underflow();
      t_both_pass();
      t_random();
      $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
      $finish;
   end

   initial begin
      #1000000;
      misses++;
      $display("FAIL watchdog: actual running expected done at %0t", $time);
      $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
      $finish;
   end

endmodule